// File: doc/BRIEF.md
# Clock Pulse Pattern Load Generator

This block produces deliberate, bursty switching activity for exercising a power delivery network at chosen subharmonics of the fast clock. A 16-bit pulse mask is shifted in one bit per clock through a serial scan port. A load-done strobe then commits it to a shadow register. From then on a pointer walks the mask one position per fast-clock cycle and wraps around. Each set bit lets the matching clock pulse out on the gated clock, and each clear bit swallows it.

Every pulse that passes also fires a bank of multiplier lanes. A shared operand select toggles between two preset values on each passed pulse. Each lane multiplies a common factor by the selected operand and registers the result, and each lane has its own enable so the switched load can be scaled. The mask sets the spacing of the bursts: alternating bits give activity at half the clock rate, four-on/four-off gives one eighth, eight-on/eight-off gives one sixteenth, and all ones gives a steady load with activity only at the clock rate.

Top module: `pulse_load_gen`

## Requirements
- R1: While rst_ni is low, and after reset until a mask is committed, gclk_o and active_o stay low and every lane result reads zero.
- R2: While scan_en_i is high, each rising clock edge shifts scan_data_i into the scan register at bit 15, moving earlier bits toward bit 0, so the first bit shifted lands at mask bit 0. The applied mask changes only on a scan_done_i edge, which copies the scan register. A scan aborted without scan_done_i leaves the applied mask unchanged.
- R3: No pulse passes for a clock edge if scan_en_i or scan_done_i was high during the cycle before it.
- R4: After the edge that samples scan_done_i, the next clock pulse is governed by mask bit 0, the one after it by bit 1, and so on.
- R5: The mask pointer advances every cycle and wraps from 15 to 0, so the pulse pattern repeats every 16 cycles.
- R6: Mask bit 1 passes its clock pulse and bit 0 suppresses it. For a passed pulse, gclk_o and active_o are high through that pulse's high phase.
- R7: Over one 16-cycle period the number of low-to-high bursts (counted circularly) is 8 for mask 16'h5555, 2 for 16'h0F0F, 1 for 16'h00FF and 16'h0001, and 0 for 16'hFFFF, which passes all 16 pulses.
- R8: gclk_o is low whenever clk_i is low, because the gating enable changes only on the falling edge.
- R9: The operand select starts at op_a_i after reset and toggles only on passed pulses. On a passed pulse each enabled lane registers mul_x_i times op_a_i when the select is clear, or times op_b_i when it is set.
- R10: Lane i drives prod_o[32*i+31:32*i]. A lane whose mul_en_i bit is low, and every lane on a suppressed pulse, holds its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scan_en_i | input | 1 | Scan shift enable; gating held off while high |
| scan_data_i | input | 1 | Serial mask bit |
| scan_done_i | input | 1 | Load-done strobe, commits the scanned mask |
| op_a_i | input | 16 | First alternating operand |
| op_b_i | input | 16 | Second alternating operand |
| mul_x_i | input | 16 | Common multiplier factor |
| mul_en_i | input | 4 | Per-lane enable |
| gclk_o | output | 1 | Gated clock |
| active_o | output | 1 | High for the duration of a passed pulse |
| prod_o | output | 128 | Lane results, 32 bits per lane |

## Verification
Two things can fall on the same clock edge: a pulse-pass decision and a scan shift or commit. The bench provokes this by starting a scan, and by aborting one, while an all-ones pattern is running. It then checks that the pulses stop in exactly the cycle after scan_en_i rises and that the old pattern carries on once the scan is aborted. It also checks that the strobe edge itself is swallowed and that the first pulse after it follows bit 0 of the new mask. The product updates and the operand toggle share each pulse edge. They are judged against a cycle model kept in the bench, alongside circular burst counts compared with a fixed table.

// File: rtl/pl_pkg.sv
package pl_pkg;
  localparam int MASK_W = 16;
  localparam int OP_W   = 16;
  localparam int LANES  = 4;
  localparam int PROD_W = 2 * OP_W;
  localparam int PTR_W  = $clog2(MASK_W);
endpackage

// File: rtl/pl_scan_reg.sv
module pl_scan_reg #(
  parameter int MASK_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              sdata_i,
  input  logic              commit_i,
  output logic [MASK_W-1:0] mask_o
);
  logic [MASK_W-1:0] shreg_q;
  logic [MASK_W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      mask_q  <= '0;
    end else begin
      if (shift_i)  shreg_q <= {sdata_i, shreg_q[MASK_W-1:1]};
      if (commit_i) mask_q  <= shreg_q;
    end
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/pl_gate.sv
module pl_gate #(
  parameter int MASK_W = 16,
  localparam int PTR_W = $clog2(MASK_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MASK_W-1:0] mask_i,
  input  logic              hold_i,
  input  logic              restart_i,
  output logic [PTR_W-1:0]  ptr_o,
  output logic              fire_o,
  output logic              gclk_o
);
  logic [PTR_W-1:0] ptr_q;
  logic             fire_q;
  logic             pass;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             ptr_q <= '0;
    else if (restart_i)                      ptr_q <= '0;
    else if (ptr_q == PTR_W'(MASK_W - 1))    ptr_q <= '0;
    else                                     ptr_q <= ptr_q + 1'b1;
  end

  assign pass = mask_i[ptr_q] & ~hold_i;

  // enable captured while clock is low, so the AND below cannot glitch
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fire_q <= 1'b0;
    else         fire_q <= pass;
  end

  assign gclk_o = clk_i & fire_q;
  assign fire_o = fire_q;
  assign ptr_o  = ptr_q;
endmodule

// File: rtl/pl_mul_lane.sv
module pl_mul_lane #(
  parameter int OP_W = 16,
  localparam int PROD_W = 2 * OP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic              en_i,
  input  logic [OP_W-1:0]   x_i,
  input  logic [OP_W-1:0]   y_i,
  output logic [PROD_W-1:0] prod_o
);
  logic [PROD_W-1:0] prod_q;
  logic [PROD_W-1:0] prod_d;

  assign prod_d = {{OP_W{1'b0}}, x_i} * {{OP_W{1'b0}}, y_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             prod_q <= '0;
    else if (fire_i && en_i) prod_q <= prod_d;
  end

  assign prod_o = prod_q;
endmodule

// File: rtl/pulse_load_gen.sv
module pulse_load_gen #(
  parameter int MASK_W = pl_pkg::MASK_W,
  parameter int OP_W   = pl_pkg::OP_W,
  parameter int LANES  = pl_pkg::LANES,
  localparam int PROD_W = 2 * OP_W,
  localparam int PTR_W  = $clog2(MASK_W)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    scan_en_i,
  input  logic                    scan_data_i,
  input  logic                    scan_done_i,
  input  logic [OP_W-1:0]         op_a_i,
  input  logic [OP_W-1:0]         op_b_i,
  input  logic [OP_W-1:0]         mul_x_i,
  input  logic [LANES-1:0]        mul_en_i,
  output logic                    gclk_o,
  output logic                    active_o,
  output logic [LANES*PROD_W-1:0] prod_o
);
  logic [MASK_W-1:0] mask;
  logic [PTR_W-1:0]  ptr_q;
  logic              fire;
  logic              sel_q;
  logic [OP_W-1:0]   opnd;

  pl_scan_reg #(.MASK_W(MASK_W)) u_scan (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .shift_i  (scan_en_i),
    .sdata_i  (scan_data_i),
    .commit_i (scan_done_i),
    .mask_o   (mask)
  );

  pl_gate #(.MASK_W(MASK_W)) u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mask_i    (mask),
    .hold_i    (scan_en_i | scan_done_i),
    .restart_i (scan_done_i),
    .ptr_o     (ptr_q),
    .fire_o    (fire),
    .gclk_o    (gclk_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sel_q <= 1'b0;
    else if (fire) sel_q <= ~sel_q;
  end

  assign opnd     = sel_q ? op_b_i : op_a_i;
  assign active_o = fire;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    pl_mul_lane #(.OP_W(OP_W)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .fire_i (fire),
      .en_i   (mul_en_i[i]),
      .x_i    (mul_x_i),
      .y_i    (opnd),
      .prod_o (prod_o[i*PROD_W +: PROD_W])
    );
  end
endmodule

// File: rtl/pulse_load_gen_chk.sv
module pulse_load_gen_chk #(
  parameter int MASK_W = 16,
  parameter int LANES  = 4,
  parameter int PROD_W = 32,
  localparam int PTR_W = $clog2(MASK_W)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    scan_en_i,
  input logic                    scan_done_i,
  input logic [LANES-1:0]        mul_en_i,
  input logic                    gclk_o,
  input logic                    active_o,
  input logic [LANES*PROD_W-1:0] prod_o,
  input logic [PTR_W-1:0]        ptr
);
  // R3
  scan_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_en_i || scan_done_i) |-> !active_o);

  // R8
  gclk_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gclk_o);

  // R5
  ptr_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr == PTR_W'(MASK_W - 1) && !scan_done_i) |=> (ptr == '0));

  // R4
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_done_i |=> (ptr == '0));

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |=> $stable(prod_o));

  for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
    // R10
    lane_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !mul_en_i[i] |=> $stable(prod_o[i*PROD_W +: PROD_W]));
  end
endmodule

bind pulse_load_gen pulse_load_gen_chk #(
  .MASK_W (MASK_W),
  .LANES  (LANES),
  .PROD_W (PROD_W)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .scan_en_i   (scan_en_i),
  .scan_done_i (scan_done_i),
  .mul_en_i    (mul_en_i),
  .gclk_o      (gclk_o),
  .active_o    (active_o),
  .prod_o      (prod_o),
  .ptr         (ptr_q)
);

// File: tb/pulse_load_gen_tb_top.sv
`timescale 1ns/1ps
module pulse_load_gen_tb_top;
  localparam int NT = 5;
  localparam logic [15:0] TBL_MASK [NT] = '{16'h5555, 16'h0F0F, 16'h00FF, 16'hFFFF, 16'h0001};
  localparam logic [3:0]  TBL_EN   [NT] = '{4'hF, 4'h5, 4'hA, 4'h1, 4'hE};
  localparam int          TBL_PULS [NT] = '{8, 8, 8, 16, 1};
  localparam int          TBL_BRST [NT] = '{8, 2, 1, 0, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scan_en = 1'b0, scan_d = 1'b0, done = 1'b0;
  logic [15:0] op_a = 16'd5, op_b = 16'd7, mx = 16'd3;
  logic [3:0]  men = 4'h0;
  logic gclk, active;
  logic [127:0] prod;

  int total = 0, bad = 0;

  logic [15:0] m_shreg = '0, m_mask = '0;
  int          m_ptr = 0;
  logic        m_sel = 1'b0;
  logic [31:0] m_prod [4] = '{default: '0};

  always #2.5 clk = ~clk;

  pulse_load_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scan_en_i(scan_en), .scan_data_i(scan_d),
    .scan_done_i(done), .op_a_i(op_a), .op_b_i(op_b), .mul_x_i(mx),
    .mul_en_i(men), .gclk_o(gclk), .active_o(active), .prod_o(prod)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic se, input logic sd, input logic dn, output logic pass);
    logic ex;
    scan_en = se; scan_d = sd; done = dn;
    ex = m_mask[m_ptr] & !se & !dn;
    #2.5;
    chk(gclk == 1'b0, "R8 gclk low phase", 32'(gclk), 0);
    @(posedge clk); #1;
    chk(gclk == ex, se ? "R3 gclk during scan" : "R6 gclk", 32'(gclk), 32'(ex));
    chk(active == ex, "R6 active", 32'(active), 32'(ex));
    if (se) m_shreg = {sd, m_shreg[15:1]};
    if (dn) m_mask = m_shreg;
    m_ptr = dn ? 0 : (m_ptr + 1) % 16;
    if (ex) begin
      for (int i = 0; i < 4; i++)
        if (men[i]) m_prod[i] = 32'(mx) * 32'(m_sel ? op_b : op_a);
      m_sel = !m_sel;
    end
    for (int i = 0; i < 4; i++)
      chk(prod[32*i +: 32] == m_prod[i], "R9/R10 lane result", prod[32*i +: 32], m_prod[i]);
    pass = ex;
  endtask

  task automatic load(input logic [15:0] m);
    logic p;
    for (int i = 0; i < 16; i++) step(1'b1, m[i], 1'b0, p);
    step(1'b0, 1'b0, 1'b1, p);
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic p;
    logic [15:0] p1, p2;
    logic [31:0] prv, cur;
    int np, nb;
    repeat (3) @(posedge clk);
    #1;
    chk(gclk == 1'b0 && active == 1'b0, "R1 reset outputs", 32'({gclk, active}), 0);
    chk(prod == '0, "R1 reset results", prod[31:0], 0);
    rst_n = 1'b1;
    men = 4'hF;
    for (int k = 0; k < 20; k++) step(1'b0, 1'b0, 1'b0, p);
    chk(prod == '0, "R1 no activity before commit", prod[31:0], 0);

    // table walk: R2, R4, R5, R7
    for (int t = 0; t < NT; t++) begin
      men = TBL_EN[t];
      op_a = 16'(100 + t); op_b = 16'(900 + 3 * t); mx = 16'(7 + t);
      load(TBL_MASK[t]);
      for (int k = 0; k < 16; k++) begin step(1'b0, 1'b0, 1'b0, p); p1[k] = p; end
      for (int k = 0; k < 16; k++) begin step(1'b0, 1'b0, 1'b0, p); p2[k] = p; end
      chk(p1 == TBL_MASK[t], "R2/R4 pulses follow mask from bit 0", 32'(p1), 32'(TBL_MASK[t]));
      chk(p2 == p1, "R5 pattern repeats", 32'(p2), 32'(p1));
      np = 0; nb = 0;
      for (int k = 0; k < 16; k++) begin
        if (p2[k]) np++;
        if (p2[k] && !p2[(k + 15) % 16]) nb++;
      end
      chk(np == TBL_PULS[t], "R7 pulses per period", 32'(np), 32'(TBL_PULS[t]));
      chk(nb == TBL_BRST[t], "R7 bursts per period", 32'(nb), 32'(TBL_BRST[t]));
    end

    // R3 and R2: scan during a running all-ones pattern, then abort
    men = 4'hF;
    load(16'hFFFF);
    for (int k = 0; k < 4; k++) step(1'b0, 1'b0, 1'b0, p);
    chk(p == 1'b1, "R6 all ones passes", 32'(p), 1);
    for (int k = 0; k < 5; k++) begin
      step(1'b1, k[0], 1'b0, p);
      chk(p == 1'b0, "R3 held during scan", 32'(p), 0);
    end
    np = 0;
    for (int k = 0; k < 16; k++) begin step(1'b0, 1'b0, 1'b0, p); if (p) np++; end
    chk(np == 16, "R2 aborted scan keeps mask", 32'(np), 16);

    // R3: strobe cycle swallowed
    step(1'b0, 1'b0, 1'b1, p);
    chk(p == 1'b0, "R3 strobe cycle held", 32'(p), 0);

    // R9: operand alternation on lane 0
    op_a = 16'd5; op_b = 16'd7; mx = 16'd3; men = 4'h1;
    load(16'hFFFF);
    prv = 32'd0;
    for (int k = 0; k < 6; k++) begin
      step(1'b0, 1'b0, 1'b0, p);
      cur = prod[31:0];
      chk(cur == 32'd15 || cur == 32'd21, "R9 product value", cur, 15);
      if (k > 0) chk(cur != prv, "R9 operand toggles", cur, prv);
      prv = cur;
    end

    // R10: lanes off hold through passed pulses
    men = 4'h0;
    prv = prod[63:32];
    for (int k = 0; k < 4; k++) step(1'b0, 1'b0, 1'b0, p);
    chk(prod[63:32] == prv, "R10 disabled lane holds", prod[63:32], prv);

    // R4: single-bit mask lands on first and seventeenth cycle
    men = 4'hF;
    load(16'h0001);
    step(1'b0, 1'b0, 1'b0, p);
    chk(p == 1'b1, "R4 bit 0 first", 32'(p), 1);
    for (int k = 0; k < 15; k++) step(1'b0, 1'b0, 1'b0, p);
    chk(p == 1'b0, "R4 bit 15 quiet", 32'(p), 0);
    step(1'b0, 1'b0, 1'b0, p);
    chk(p == 1'b1, "R5 wrap to bit 0", 32'(p), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule